// File: doc/BRIEF.md
# Registered Carry-Select Adder/Subtractor

This block adds or subtracts two WIDTH-bit operands each cycle. The datapath is a chain of 10-bit slices. Each slice holds two 5-bit groups. Every group works out its sum bits and its carry-out twice, in parallel: once assuming the incoming carry is 0 and once assuming it is 1. The carry that actually arrives at the group then picks one of the two results. As a result, only the group-to-group carries lie on the long timing path, and the ripple inside each group does not.

A per-cycle control bit chooses between addition and subtraction. For subtraction, operand B is inverted bit by bit and the control bit is fed in as the carry of bit 0, so the result is A + ~B + 1. No other carry in the chain sees this bit.

The sum bits, the final carry-out and a signed overflow flag can be captured in an output register. That register has the following controls:
- asynchronous clear
- asynchronous load from a preset word
- synchronous clear
- synchronous load from a load word
- clock enable

A bypass input sends the combinational result straight to the outputs instead.

Top module: `csel_addsub_reg`

## Requirements
- R1: When `reg_bypass`=1, `sum_o` equals A+B (`sub`=0) or A−B (`sub`=1), modulo 2^WIDTH, in the same cycle.
- R2: When `reg_bypass`=1, `cout_o` is the unsigned carry-out of A+B when adding. When subtracting it is 1 exactly when A ≥ B as unsigned numbers (no borrow).
- R3: When `reg_bypass`=1, `ovf_o` is 1 exactly when the two's-complement result overflows. For addition that means the operands have equal sign bits and the sum's sign differs from A. For subtraction it means the operand sign bits differ and the result's sign differs from A.
- R4: When `reg_bypass`=0, and with `en`=1, `sync_clr`=0 and `sync_ld`=0, the sum, carry and overflow of the operands present at a rising edge appear on the outputs right after that edge.
- R5: With `en`=0, a rising edge leaves the registered sum and flags unchanged, whatever `sync_clr`, `sync_ld` and the operands are.
- R6: With `en`=1 and `sync_clr`=1, the rising edge clears sum and flags to 0. Synchronous clear wins over synchronous load.
- R7: With `en`=1, `sync_clr`=0 and `sync_ld`=1, the rising edge loads `load_data` into the sum register and clears both flags.
- R8: While `async_ld`=1 (and `async_clr_n`=1), the sum register holds `preset_data` and both flags are 0. This happens without waiting for a clock and regardless of `en`.
- R9: While `async_clr_n`=0, the sum register and flags are 0 at once. Asynchronous clear wins over asynchronous load.
- R10: Carries cross 5-bit group and 10-bit slice boundaries correctly. Examples: 0x1F+1 gives 0x20, 0x3FF+1 gives 0x400, and all-ones+1 gives 0 with `cout_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| async_clr_n | input | 1 | Asynchronous clear, active low; also serves as reset |
| async_ld | input | 1 | Asynchronous load of `preset_data`, active high |
| preset_data | input | WIDTH | Word taken by the asynchronous load |
| en | input | 1 | Clock enable for all synchronous updates |
| sync_clr | input | 1 | Synchronous clear |
| sync_ld | input | 1 | Synchronous load of `load_data` |
| load_data | input | WIDTH | Word taken by the synchronous load |
| sub | input | 1 | 0 = add, 1 = subtract |
| reg_bypass | input | 1 | 1 = combinational outputs, 0 = registered outputs |
| a | input | WIDTH | Operand A |
| b | input | WIDTH | Operand B |
| sum_o | output | WIDTH | Sum or difference |
| cout_o | output | 1 | Final carry-out |
| ovf_o | output | 1 | Signed overflow |

## Verification
Each kind of result has its own timing, and the checks follow it:
- Bypassed results settle within the same cycle. The bench drives operands at a falling edge and samples 1 ns later.
- Registered results are due just after the first rising edge following the drive. The bench samples them at the next falling edge, half a period later, and updates its own register model at that rising edge.
- Asynchronous clear and load act with no clock. They are sampled 1 ns after the control pin changes. They are held across at least one rising edge and released on a falling edge, so the edge-based checks are never caught mid-pulse.

// File: rtl/csel_pkg.sv
`timescale 1ns/1ps
package csel_pkg;
  // Synchronous controls shared by every bit of the output register
  typedef struct packed {
    logic en;
    logic sclr;
    logic sload;
  } reg_ctl_t;
endpackage

// File: rtl/csel_group.sv
`timescale 1ns/1ps
// One carry-select group: two precomputed carry rails, real carry picks one
module csel_group #(
  parameter int GW = 5
) (
  input  logic [GW-1:0] a,
  input  logic [GW-1:0] b,
  input  logic          cin,
  output logic [GW-1:0] sum,
  output logic          cout
);
  logic [GW:0] rail0;
  logic [GW:0] rail1;

  assign rail0[0] = 1'b0;
  assign rail1[0] = 1'b1;

  for (genvar i = 0; i < GW; i++) begin : g_bit
    logic prop;
    logic gen;
    assign prop       = a[i] ^ b[i];
    assign gen        = a[i] & b[i];
    assign rail0[i+1] = gen | (prop & rail0[i]);
    assign rail1[i+1] = gen | (prop & rail1[i]);
    assign sum[i]     = prop ^ (cin ? rail1[i] : rail0[i]);
  end

  assign cout = cin ? rail1[GW] : rail0[GW];
endmodule

// File: rtl/csel_slice.sv
`timescale 1ns/1ps
// One slice: a short chain of carry-select groups
module csel_slice #(
  parameter int SLICE_W = 10,
  parameter int GROUP_W = 5
) (
  input  logic [SLICE_W-1:0] a,
  input  logic [SLICE_W-1:0] b,
  input  logic               cin,
  output logic [SLICE_W-1:0] sum,
  output logic               cout
);
  localparam int N_GRP = SLICE_W / GROUP_W;

  logic [N_GRP:0] gcarry;
  assign gcarry[0] = cin;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    csel_group #(.GW(GROUP_W)) u_grp (
      .a    (a[g*GROUP_W +: GROUP_W]),
      .b    (b[g*GROUP_W +: GROUP_W]),
      .cin  (gcarry[g]),
      .sum  (sum[g*GROUP_W +: GROUP_W]),
      .cout (gcarry[g+1])
    );
  end

  assign cout = gcarry[N_GRP];
endmodule

// File: rtl/csel_outreg.sv
`timescale 1ns/1ps
// Output register bank with shared async/sync load and clear controls
module csel_outreg
  import csel_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         aclr_n,
  input  logic         aload,
  input  logic [W-1:0] adata,
  input  reg_ctl_t     ctl,
  input  logic [W-1:0] sdata,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge aclr_n or posedge aload) begin
    if (!aclr_n)
      q <= '0;
    else if (aload)
      q <= adata;
    else if (ctl.en) begin
      if (ctl.sclr)
        q <= '0;
      else if (ctl.sload)
        q <= sdata;
      else
        q <= d;
    end
  end
endmodule

// File: rtl/csel_addsub_reg.sv
`timescale 1ns/1ps
module csel_addsub_reg
  import csel_pkg::*;
#(
  parameter int WIDTH   = 40,
  parameter int SLICE_W = 10,
  parameter int GROUP_W = 5
) (
  input  logic             clk,
  input  logic             async_clr_n,
  input  logic             async_ld,
  input  logic [WIDTH-1:0] preset_data,
  input  logic             en,
  input  logic             sync_clr,
  input  logic             sync_ld,
  input  logic [WIDTH-1:0] load_data,
  input  logic             sub,
  input  logic             reg_bypass,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int N_SLICE = WIDTH / SLICE_W;

  if ((WIDTH % SLICE_W) != 0 || (SLICE_W % GROUP_W) != 0) begin : g_bad_cfg
    $error("csel_addsub_reg: WIDTH must be a multiple of SLICE_W, SLICE_W of GROUP_W");
  end

  logic [WIDTH-1:0]   b_eff;
  logic [WIDTH-1:0]   sum_c;
  logic [N_SLICE:0]   chain;
  logic               msb_cin;
  logic               ovf_c;
  logic [WIDTH-1:0]   sum_q;
  logic [1:0]         flag_q;
  reg_ctl_t           ctl;

  // Subtract: invert B and inject 1 at bit 0 only
  assign b_eff    = sub ? ~b : b;
  assign chain[0] = sub;

  for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
    csel_slice #(.SLICE_W(SLICE_W), .GROUP_W(GROUP_W)) u_slice (
      .a    (a[s*SLICE_W +: SLICE_W]),
      .b    (b_eff[s*SLICE_W +: SLICE_W]),
      .cin  (chain[s]),
      .sum  (sum_c[s*SLICE_W +: SLICE_W]),
      .cout (chain[s+1])
    );
  end

  // Carry into the sign bit, recovered from its sum bit
  assign msb_cin = sum_c[WIDTH-1] ^ a[WIDTH-1] ^ b_eff[WIDTH-1];
  assign ovf_c   = msb_cin ^ chain[N_SLICE];

  assign ctl = '{en: en, sclr: sync_clr, sload: sync_ld};

  csel_outreg #(.W(WIDTH)) u_sum_reg (
    .clk    (clk),
    .aclr_n (async_clr_n),
    .aload  (async_ld),
    .adata  (preset_data),
    .ctl    (ctl),
    .sdata  (load_data),
    .d      (sum_c),
    .q      (sum_q)
  );

  // Flags: both loads force them to zero
  csel_outreg #(.W(2)) u_flag_reg (
    .clk    (clk),
    .aclr_n (async_clr_n),
    .aload  (async_ld),
    .adata  (2'b00),
    .ctl    (ctl),
    .sdata  (2'b00),
    .d      ({ovf_c, chain[N_SLICE]}),
    .q      (flag_q)
  );

  assign sum_o  = reg_bypass ? sum_c          : sum_q;
  assign cout_o = reg_bypass ? chain[N_SLICE] : flag_q[0];
  assign ovf_o  = reg_bypass ? ovf_c          : flag_q[1];
endmodule

// File: rtl/csel_addsub_chk.sv
`timescale 1ns/1ps
module csel_addsub_chk #(
  parameter int WIDTH = 40
) (
  input logic             clk,
  input logic             async_clr_n,
  input logic             async_ld,
  input logic [WIDTH-1:0] preset_data,
  input logic             en,
  input logic             sync_clr,
  input logic             sync_ld,
  input logic [WIDTH-1:0] load_data,
  input logic             sub,
  input logic             reg_bypass,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o,
  input logic             ovf_o,
  input logic [WIDTH-1:0] sum_q,
  input logic [1:0]       flag_q
);
  logic [WIDTH-1:0] ref_sum;
  logic [WIDTH:0]   ref_wide;
  logic             ref_c;
  logic             ref_v;

  always_comb begin
    ref_wide = {1'b0, a} + {1'b0, b};
    ref_sum  = sub ? (a - b) : (a + b);
    ref_c    = sub ? (a >= b) : ref_wide[WIDTH];
    ref_v    = sub ? ((a[WIDTH-1] != b[WIDTH-1]) && (ref_sum[WIDTH-1] != a[WIDTH-1]))
                   : ((a[WIDTH-1] == b[WIDTH-1]) && (ref_sum[WIDTH-1] != a[WIDTH-1]));
  end

  // R1
  bypass_sum_chk: assert property (@(posedge clk) disable iff (!async_clr_n)
    reg_bypass |-> sum_o == ref_sum);
  // R2
  bypass_carry_chk: assert property (@(posedge clk) disable iff (!async_clr_n)
    reg_bypass |-> cout_o == ref_c);
  // R3
  bypass_ovf_chk: assert property (@(posedge clk) disable iff (!async_clr_n)
    reg_bypass |-> ovf_o == ref_v);
  // R4
  reg_capture_chk: assert property (@(posedge clk) disable iff (!async_clr_n)
    (en && !sync_clr && !sync_ld && !async_ld) |=>
      (async_ld || (sum_q == $past(ref_sum) && flag_q == $past({ref_v, ref_c}))));
  // R5
  enable_hold_chk: assert property (@(posedge clk) disable iff (!async_clr_n)
    (!en && !async_ld) |=> (async_ld || ($stable(sum_q) && $stable(flag_q))));
  // R6
  sync_clear_chk: assert property (@(posedge clk) disable iff (!async_clr_n)
    (en && sync_clr && !async_ld) |=> (async_ld || (sum_q == '0 && flag_q == 2'b00)));
  // R7
  sync_load_chk: assert property (@(posedge clk) disable iff (!async_clr_n)
    (en && !sync_clr && sync_ld && !async_ld) |=>
      (async_ld || (sum_q == $past(load_data) && flag_q == 2'b00)));
  // R8
  async_load_chk: assert property (@(posedge clk) disable iff (!async_clr_n)
    (async_ld && $past(async_ld) && $stable(preset_data)) |->
      (sum_q == preset_data && flag_q == 2'b00));
  // R9
  async_clear_chk: assert property (@(posedge clk)
    !async_clr_n |-> (sum_q == '0 && flag_q == 2'b00));
endmodule

bind csel_addsub_reg csel_addsub_chk #(.WIDTH(WIDTH)) u_csel_chk (.*);

// File: tb/test_csel_addsub_reg.sv
`timescale 1ns/1ps
module test_csel_addsub_reg;
  localparam int W = 40;

  logic         clk = 1'b0;
  logic         async_clr_n = 1'b1;
  logic         async_ld = 1'b0;
  logic [W-1:0] preset_data = '0;
  logic         en = 1'b0;
  logic         sync_clr = 1'b0;
  logic         sync_ld = 1'b0;
  logic [W-1:0] load_data = '0;
  logic         sub = 1'b0;
  logic         reg_bypass = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [W-1:0] sum_o;
  logic         cout_o;
  logic         ovf_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  logic [W-1:0] exp_q = '0;
  logic         exp_c = 1'b0;
  logic         exp_v = 1'b0;

  always #2.5 clk = ~clk;

  csel_addsub_reg #(.WIDTH(W)) i_csel_addsub_reg (
    .clk, .async_clr_n, .async_ld, .preset_data, .en, .sync_clr, .sync_ld,
    .load_data, .sub, .reg_bypass, .a, .b, .sum_o, .cout_o, .ovf_o
  );

  function automatic logic [W-1:0] f_sum(logic [W-1:0] x, logic [W-1:0] y, logic s);
    return s ? x - y : x + y;
  endfunction

  function automatic logic f_carry(logic [W-1:0] x, logic [W-1:0] y, logic s);
    logic [W:0] t;
    t = {1'b0, x} + {1'b0, y};
    return s ? (x >= y) : t[W];
  endfunction

  function automatic logic f_ovf(logic [W-1:0] x, logic [W-1:0] y, logic s);
    logic [W-1:0] r;
    r = f_sum(x, y, s);
    if (s) return (x[W-1] != y[W-1]) && (r[W-1] != x[W-1]);
    return (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]);
  endfunction

  function automatic logic [W-1:0] rnd_word();
    return {$urandom, $urandom};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  // Bypass check: drive at a falling edge, sample 1 ns later
  task automatic comb_check(input logic [W-1:0] x, input logic [W-1:0] y,
                            input logic s, input string stag);
    reg_bypass = 1'b1;
    a = x; b = y; sub = s;
    #1;
    chk(stag, sum_o, f_sum(x, y, s));
    chk("R2 carry", cout_o, f_carry(x, y, s));
    chk("R3 overflow", ovf_o, f_ovf(x, y, s));
    @(negedge clk);
  endtask

  // Registered step: drive at a falling edge, model at the rising edge,
  // sample at the following falling edge
  task automatic step(input logic [W-1:0] x, input logic [W-1:0] y, input logic s,
                      input logic e, input logic sc, input logic sl,
                      input logic [W-1:0] ld);
    string tag;
    reg_bypass = 1'b0;
    a = x; b = y; sub = s; en = e; sync_clr = sc; sync_ld = sl; load_data = ld;
    @(posedge clk);
    if (!e) tag = "R5 hold";
    else if (sc) begin
      tag = "R6 sync clear"; exp_q = '0; exp_c = 0; exp_v = 0;
    end else if (sl) begin
      tag = "R7 sync load"; exp_q = ld; exp_c = 0; exp_v = 0;
    end else begin
      tag = "R4 capture"; exp_q = f_sum(x, y, s);
      exp_c = f_carry(x, y, s); exp_v = f_ovf(x, y, s);
    end
    @(negedge clk);
    chk(tag, sum_o, exp_q);
    chk(tag, cout_o, exp_c);
    chk(tag, ovf_o, exp_v);
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [W-1:0] ones;
    logic [W-1:0] maxpos;
    logic [W-1:0] minneg;
    ones   = '1;
    maxpos = {1'b0, {(W-1){1'b1}}};
    minneg = {1'b1, {(W-1){1'b0}}};
    void'($urandom(32'd20240611));

    // R9: reset through asynchronous clear
    #1 async_clr_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R9 reset sum", sum_o, '0);
    chk("R9 reset flags", {cout_o, ovf_o}, 2'b00);
    async_clr_n = 1'b1;
    @(negedge clk);

    // Directed bypass corners, R10 boundary carries
    comb_check('h1F, 'h1, 1'b0, "R10 group boundary");
    comb_check('h3FF, 'h1, 1'b0, "R10 slice boundary");
    comb_check(ones, 'h1, 1'b0, "R10 full wrap");
    comb_check('0, '0, 1'b0, "R1 zero add");
    comb_check('0, '0, 1'b1, "R1 zero sub");
    comb_check('0, 'h1, 1'b1, "R1 borrow");
    comb_check(ones, ones, 1'b0, "R1 ones add");
    comb_check(ones, ones, 1'b1, "R1 ones sub");
    comb_check(maxpos, 'h1, 1'b0, "R1 pos overflow");
    comb_check(minneg, 'h1, 1'b1, "R1 neg overflow");
    comb_check(minneg, minneg, 1'b0, "R1 neg add");
    for (int i = 0; i < 200; i++)
      comb_check(rnd_word(), rnd_word(), 1'($urandom), "R1 random");

    // Registered mode, directed then random controls
    step(ones, 'h1, 1'b0, 1'b1, 1'b0, 1'b0, '0);
    step(maxpos, 'h1, 1'b0, 1'b1, 1'b0, 1'b0, '0);
    step('0, '0, 1'b0, 1'b0, 1'b1, 1'b1, rnd_word());
    step(rnd_word(), rnd_word(), 1'b1, 1'b1, 1'b1, 1'b1, rnd_word());
    step(rnd_word(), rnd_word(), 1'b0, 1'b1, 1'b0, 1'b1, rnd_word());
    for (int i = 0; i < 300; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step(rnd_word(), rnd_word(), 1'($urandom), (r >= 20),
           ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0), rnd_word());
    end

    // R8: asynchronous load, held across two edges with enable on
    preset_data = rnd_word();
    a = rnd_word(); b = rnd_word(); en = 1'b1; sync_clr = 0; sync_ld = 0;
    async_ld = 1'b1;
    #1;
    chk("R8 immediate", sum_o, preset_data);
    chk("R8 flags", {cout_o, ovf_o}, 2'b00);
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk("R8 held", sum_o, preset_data);
    async_ld = 1'b0;
    exp_q = preset_data; exp_c = 0; exp_v = 0;
    step(rnd_word(), rnd_word(), 1'b0, 1'b0, 1'b0, 1'b0, '0);

    // R9: async clear beats async load
    preset_data = rnd_word() | 'h1;
    async_ld = 1'b1;
    async_clr_n = 1'b0;
    #1;
    chk("R9 clear over load", sum_o, '0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 clear held", sum_o, '0);
    async_clr_n = 1'b1;
    async_ld = 1'b0;
    #1;
    chk("R9 after release", sum_o, '0);
    exp_q = '0; exp_c = 0; exp_v = 0;
    @(negedge clk);
    step(rnd_word(), rnd_word(), 1'b1, 1'b1, 1'b0, 1'b0, '0);

    report();
  end
endmodule